// File: doc/BRIEF.md
# Shadowed Load Release Queue

This block sits between the shadow tracker, which holds the instructions whose outcome can still squash younger work in program order, and the load/store unit. A load allocated in the load queue while the tracker holds at least one shadow caster must not go to memory yet. When that happens, the queue stores a link from the load's queue index to the tracker index of the youngest caster present at that moment. In the same cycle it tells the load/store unit that the new load is shadowed.

The tracker later resolves its entries in order and reports at most one resolution per cycle. A resolution carries a tracker index and a killed flag. If the resolution is not killed, every linked load whose stored tracker index matches is woken: its load-queue index goes out on one of a parameterised number of clear ports, and its entry is freed. If there are more matches than ports, the extra matches wait and go out in later cycles. If the resolution is killed, the matching links are dropped and no clear is sent. The queue has no link to branch or execution units. It learns of squashes only from the tracker.

Top module: `ld_release_q`

## Requirements
- R1: `shadowed_o` is high in the same cycle as `alloc_valid_i` when `sb_nonempty_i` is high and the queue has a free entry, and in that case the load is recorded. In every other case `shadowed_o` is low.
- R2: A load allocated while `sb_nonempty_i` is low creates no entry, so no later resolution produces a clear for it.
- R3: A resolution that is not killed (`rel_valid_i`=1, `rel_killed_i`=0) drives the load-queue index of each matching entry onto a clear port in the same cycle as the resolution.
- R4: There are `NUM_CLR` clear ports. Port k occupies bits [k*LQ_W +: LQ_W] of `clr_lq_idx_o` and bit k of `clr_valid_o`. Ports fill from port 0 upward. Waiting matches are served lowest entry slot first, and matches that do not fit stay pending to later cycles.
- R5: A killed resolution (`rel_killed_i`=1) produces no clear. The matching entries are dropped, so a later resolution with the same index also produces no clear.
- R6: When every entry is occupied and a load arrives with `sb_nonempty_i` high, `stall_o` is high, `shadowed_o` is low, and no entry is created.
- R7: An entry is freed in the cycle its clear is issued and can be allocated again from the next cycle.
- R8: A resolution whose index matches no waiting entry produces no clear.
- R9: A load allocated in the same cycle as a resolution is not matched by that resolution.
- R10: Asynchronous active-low reset empties the queue and leaves all outputs low while no load is allocated.
- R11: New loads take the lowest free entry slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | A load is being allocated in the load queue |
| alloc_lq_idx_i | input | LQ_W | Load-queue index of that load |
| sb_nonempty_i | input | 1 | The shadow tracker holds at least one caster |
| sb_tail_idx_i | input | SB_W | Tracker index of the youngest caster |
| rel_valid_i | input | 1 | The tracker resolves an entry this cycle |
| rel_idx_i | input | SB_W | Tracker index being resolved |
| rel_killed_i | input | 1 | The resolved entry was squashed |
| shadowed_o | output | 1 | The load being allocated is recorded as shadowed |
| stall_o | output | 1 | The queue is full; decode must stall |
| clr_valid_o | output | NUM_CLR | Per-port clear request valid |
| clr_lq_idx_o | output | NUM_CLR*LQ_W | Per-port load-queue index to unshadow |

## Verification
The bench builds the queue with four entries and two clear ports. It uses a 4-bit load index and a 3-bit tracker index. With four entries, the full condition and its stall are reached after only a handful of loads. With two ports, a resolution that matches three loads overflows the ports and forces a pending clear into the next cycle. The small tracker index lets one index be reused after a kill, so the bench can confirm that the dropped links stay gone.

// File: rtl/ld_release_pkg.sv
package ld_release_pkg;
  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,
    ENT_WAIT  = 2'd1,
    ENT_READY = 2'd2
  } ent_state_e;
endpackage

// File: rtl/ld_release_entry.sv
module ld_release_entry
  import ld_release_pkg::*;
#(
  parameter int unsigned LQ_W = 4,
  parameter int unsigned SB_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [LQ_W-1:0] wr_lq_i,
  input  logic [SB_W-1:0] wr_sb_i,
  input  logic            rel_valid_i,
  input  logic [SB_W-1:0] rel_idx_i,
  input  logic            rel_killed_i,
  input  logic            grant_i,
  output logic            req_o,
  output logic            busy_o,
  output logic            ready_o,
  output logic [LQ_W-1:0] lq_o
);
  ent_state_e      state_q, state_d;
  logic [LQ_W-1:0] lq_q;
  logic [SB_W-1:0] sb_q;
  logic            match;

  // only waiting entries match; pending ones are already released
  assign match   = rel_valid_i && (state_q == ENT_WAIT) && (sb_q == rel_idx_i);
  assign req_o   = (match && !rel_killed_i) || (state_q == ENT_READY);
  assign busy_o  = (state_q != ENT_FREE);
  assign ready_o = (state_q == ENT_READY);
  assign lq_o    = lq_q;

  always_comb begin
    state_d = state_q;
    if (wr_i)                       state_d = ENT_WAIT;
    else if (grant_i)               state_d = ENT_FREE;
    else if (match && rel_killed_i) state_d = ENT_FREE;
    else if (match)                 state_d = ENT_READY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENT_FREE;
      lq_q    <= '0;
      sb_q    <= '0;
    end else begin
      state_q <= state_d;
      if (wr_i) begin
        lq_q <= wr_lq_i;
        sb_q <= wr_sb_i;
      end
    end
  end
endmodule

// File: rtl/ld_release_free_pick.sv
module ld_release_free_pick #(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned ENT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] busy_i,
  output logic             full_o,
  output logic [ENT_W-1:0] slot_o
);
  always_comb begin
    slot_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!busy_i[i]) slot_o = ENT_W'(i);
    end
  end
  assign full_o = &busy_i;
endmodule

// File: rtl/ld_release_port_arb.sv
module ld_release_port_arb #(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned NUM_CLR = 2,
  localparam int unsigned ENT_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0]             req_i,
  output logic [DEPTH-1:0]             grant_o,
  output logic [NUM_CLR-1:0]           port_valid_o,
  output logic [NUM_CLR-1:0][ENT_W-1:0] port_sel_o
);
  always_comb begin
    int unsigned used;
    used         = 0;
    grant_o      = '0;
    port_valid_o = '0;
    port_sel_o   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (req_i[i] && used < NUM_CLR) begin
        grant_o[i] = 1'b1;
        for (int p = 0; p < NUM_CLR; p++) begin
          if (p == int'(used)) begin
            port_valid_o[p] = 1'b1;
            port_sel_o[p]   = ENT_W'(i);
          end
        end
        used = used + 1;
      end
    end
  end
endmodule

// File: rtl/ld_release_q.sv
module ld_release_q #(
  parameter int unsigned LQ_W    = 4,
  parameter int unsigned SB_W    = 3,
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned NUM_CLR = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    alloc_valid_i,
  input  logic [LQ_W-1:0]         alloc_lq_idx_i,
  input  logic                    sb_nonempty_i,
  input  logic [SB_W-1:0]         sb_tail_idx_i,
  input  logic                    rel_valid_i,
  input  logic [SB_W-1:0]         rel_idx_i,
  input  logic                    rel_killed_i,
  output logic                    shadowed_o,
  output logic                    stall_o,
  output logic [NUM_CLR-1:0]      clr_valid_o,
  output logic [NUM_CLR*LQ_W-1:0] clr_lq_idx_o
);
  localparam int unsigned ENT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]              busy_q, ready_q, req, grant, wr;
  logic [DEPTH-1:0][LQ_W-1:0]    ent_lq;
  logic                          full, want_entry;
  logic [ENT_W-1:0]              free_slot;
  logic [NUM_CLR-1:0][ENT_W-1:0] port_sel;

  assign want_entry = alloc_valid_i && sb_nonempty_i;
  assign shadowed_o = want_entry && !full;
  assign stall_o    = want_entry && full;

  ld_release_free_pick #(.DEPTH(DEPTH)) i_free_pick (
    .busy_i (busy_q),
    .full_o (full),
    .slot_o (free_slot)
  );

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    assign wr[e] = shadowed_o && (free_slot == ENT_W'(e));
    ld_release_entry #(.LQ_W(LQ_W), .SB_W(SB_W)) i_entry (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (wr[e]),
      .wr_lq_i      (alloc_lq_idx_i),
      .wr_sb_i      (sb_tail_idx_i),
      .rel_valid_i  (rel_valid_i),
      .rel_idx_i    (rel_idx_i),
      .rel_killed_i (rel_killed_i),
      .grant_i      (grant[e]),
      .req_o        (req[e]),
      .busy_o       (busy_q[e]),
      .ready_o      (ready_q[e]),
      .lq_o         (ent_lq[e])
    );
  end

  ld_release_port_arb #(.DEPTH(DEPTH), .NUM_CLR(NUM_CLR)) i_port_arb (
    .req_i        (req),
    .grant_o      (grant),
    .port_valid_o (clr_valid_o),
    .port_sel_o   (port_sel)
  );

  for (genvar p = 0; p < NUM_CLR; p++) begin : g_port
    assign clr_lq_idx_o[p*LQ_W +: LQ_W] = clr_valid_o[p] ? ent_lq[port_sel[p]] : '0;
  end
endmodule

// File: rtl/ld_release_q_chk.sv
module ld_release_q_chk #(
  parameter int unsigned DEPTH   = 4,
  parameter int unsigned NUM_CLR = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               alloc_valid_i,
  input logic               sb_nonempty_i,
  input logic               rel_valid_i,
  input logic               rel_killed_i,
  input logic               shadowed_o,
  input logic               stall_o,
  input logic [NUM_CLR-1:0] clr_valid_o,
  input logic [DEPTH-1:0]   busy_q,
  input logic [DEPTH-1:0]   ready_q
);
  AST_SHADOW_RECORDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadowed_o |=> |busy_q); // R1
  AST_SHADOW_NEEDS_CASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shadowed_o |-> (alloc_valid_i && sb_nonempty_i)); // R2
  AST_STALL_ONLY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ((&busy_q) && !shadowed_o)); // R6
  AST_KILL_NO_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rel_valid_i && rel_killed_i && (ready_q == '0)) |-> (clr_valid_o == '0)); // R5
  AST_CLR_PORTS_PACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_valid_o & (clr_valid_o + 1'b1)) == '0); // R4
  AST_CLR_FROM_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(clr_valid_o) <= $countones(busy_q)); // R3
  AST_NO_CLR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rel_valid_i && (ready_q == '0)) |-> (clr_valid_o == '0)); // R8
endmodule

bind ld_release_q ld_release_q_chk #(.DEPTH(DEPTH), .NUM_CLR(NUM_CLR)) i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .alloc_valid_i (alloc_valid_i),
  .sb_nonempty_i (sb_nonempty_i),
  .rel_valid_i   (rel_valid_i),
  .rel_killed_i  (rel_killed_i),
  .shadowed_o    (shadowed_o),
  .stall_o       (stall_o),
  .clr_valid_o   (clr_valid_o),
  .busy_q        (busy_q),
  .ready_q       (ready_q)
);

// File: tb/test_ld_release_q.sv
module test_ld_release_q;
  localparam int CLK_PERIOD = 10;
  localparam int LQ_W = 4, SB_W = 3, DEPTH = 4, NUM_CLR = 2;

  typedef struct packed {
    logic [3:0] req;
    logic       av;
    logic [3:0] lq;
    logic       ne;
    logic [2:0] sbi;
    logic       rv;
    logic [2:0] ri;
    logic       rk;
    logic       e_sh;
    logic       e_st;
    logic [1:0] e_cv;
    logic [3:0] e_l0;
    logic [3:0] e_l1;
  } vec_t;

  // req, av,lq,ne,sbi, rv,ri,rk, sh,st,cv,l0,l1
  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{4'd10, 1'b0,4'd0, 1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0,2'b00,4'd0, 4'd0},  // R10 idle
    '{4'd2,  1'b1,4'd1, 1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0,2'b00,4'd0, 4'd0},  // R2 unshadowed
    '{4'd1,  1'b1,4'd2, 1'b1,3'd3, 1'b0,3'd0,1'b0, 1'b1,1'b0,2'b00,4'd0, 4'd0},  // R1 slot0
    '{4'd1,  1'b1,4'd5, 1'b1,3'd3, 1'b0,3'd0,1'b0, 1'b1,1'b0,2'b00,4'd0, 4'd0},  // R1 slot1
    '{4'd11, 1'b1,4'd7, 1'b1,3'd3, 1'b0,3'd0,1'b0, 1'b1,1'b0,2'b00,4'd0, 4'd0},  // R11 slot2
    '{4'd3,  1'b0,4'd0, 1'b0,3'd0, 1'b1,3'd3,1'b0, 1'b0,1'b0,2'b11,4'd2, 4'd5},  // R3 both ports
    '{4'd4,  1'b0,4'd0, 1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0,2'b01,4'd7, 4'd0},  // R4 pending drains
    '{4'd7,  1'b0,4'd0, 1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0,2'b00,4'd0, 4'd0},  // R7 nothing left
    '{4'd2,  1'b0,4'd0, 1'b0,3'd0, 1'b1,3'd3,1'b0, 1'b0,1'b0,2'b00,4'd0, 4'd0},  // R2 no entry for lq1
    '{4'd1,  1'b1,4'd9, 1'b1,3'd5, 1'b0,3'd0,1'b0, 1'b1,1'b0,2'b00,4'd0, 4'd0},  // R1
    '{4'd5,  1'b0,4'd0, 1'b0,3'd0, 1'b1,3'd5,1'b1, 1'b0,1'b0,2'b00,4'd0, 4'd0},  // R5 killed
    '{4'd5,  1'b0,4'd0, 1'b0,3'd0, 1'b1,3'd5,1'b0, 1'b0,1'b0,2'b00,4'd0, 4'd0},  // R5 dropped
    '{4'd1,  1'b1,4'd10,1'b1,3'd6, 1'b0,3'd0,1'b0, 1'b1,1'b0,2'b00,4'd0, 4'd0},  // R1
    '{4'd1,  1'b1,4'd11,1'b1,3'd6, 1'b0,3'd0,1'b0, 1'b1,1'b0,2'b00,4'd0, 4'd0},  // R1
    '{4'd1,  1'b1,4'd12,1'b1,3'd6, 1'b0,3'd0,1'b0, 1'b1,1'b0,2'b00,4'd0, 4'd0},  // R1
    '{4'd1,  1'b1,4'd13,1'b1,3'd6, 1'b0,3'd0,1'b0, 1'b1,1'b0,2'b00,4'd0, 4'd0},  // R1 now full
    '{4'd6,  1'b1,4'd14,1'b1,3'd6, 1'b0,3'd0,1'b0, 1'b0,1'b1,2'b00,4'd0, 4'd0},  // R6 stall
    '{4'd8,  1'b0,4'd0, 1'b0,3'd0, 1'b1,3'd2,1'b0, 1'b0,1'b0,2'b00,4'd0, 4'd0},  // R8 no match
    '{4'd4,  1'b0,4'd0, 1'b0,3'd0, 1'b1,3'd6,1'b0, 1'b0,1'b0,2'b11,4'd10,4'd11}, // R4 lowest first
    '{4'd7,  1'b1,4'd15,1'b1,3'd1, 1'b0,3'd0,1'b0, 1'b1,1'b0,2'b11,4'd12,4'd13}, // R7 reuse + pending
    '{4'd6,  1'b0,4'd0, 1'b0,3'd0, 1'b1,3'd6,1'b0, 1'b0,1'b0,2'b00,4'd0, 4'd0},  // R6 stalled load absent
    '{4'd9,  1'b1,4'd3, 1'b1,3'd1, 1'b1,3'd1,1'b0, 1'b1,1'b0,2'b01,4'd15,4'd0},  // R9 same-cycle
    '{4'd9,  1'b0,4'd0, 1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0,2'b00,4'd0, 4'd0},  // R9 not matched
    '{4'd3,  1'b0,4'd0, 1'b0,3'd0, 1'b1,3'd1,1'b0, 1'b0,1'b0,2'b01,4'd3, 4'd0},  // R3
    '{4'd8,  1'b0,4'd0, 1'b0,3'd0, 1'b0,3'd0,1'b0, 1'b0,1'b0,2'b00,4'd0, 4'd0}   // R8 quiet
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic alloc_valid_i, sb_nonempty_i, rel_valid_i, rel_killed_i;
  logic [LQ_W-1:0] alloc_lq_idx_i;
  logic [SB_W-1:0] sb_tail_idx_i, rel_idx_i;
  logic shadowed_o, stall_o;
  logic [NUM_CLR-1:0] clr_valid_o;
  logic [NUM_CLR*LQ_W-1:0] clr_lq_idx_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ld_release_q #(.LQ_W(LQ_W), .SB_W(SB_W), .DEPTH(DEPTH), .NUM_CLR(NUM_CLR)) i_ld_release_q (
    .clk_i, .rst_ni, .alloc_valid_i, .alloc_lq_idx_i, .sb_nonempty_i, .sb_tail_idx_i,
    .rel_valid_i, .rel_idx_i, .rel_killed_i, .shadowed_o, .stall_o, .clr_valid_o, .clr_lq_idx_o
  );

  task automatic check(input int rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    alloc_valid_i = v.av; alloc_lq_idx_i = v.lq; sb_nonempty_i = v.ne; sb_tail_idx_i = v.sbi;
    rel_valid_i = v.rv; rel_idx_i = v.ri; rel_killed_i = v.rk;
  endtask

  task automatic expect_vec(input vec_t v);
    check(int'(v.req), "shadowed", {7'd0, shadowed_o}, {7'd0, v.e_sh});
    check(int'(v.req), "stall", {7'd0, stall_o}, {7'd0, v.e_st});
    check(int'(v.req), "clr_valid", {6'd0, clr_valid_o}, {6'd0, v.e_cv});
    if (v.e_cv[0]) check(int'(v.req), "port0 idx", {4'd0, clr_lq_idx_o[3:0]}, {4'd0, v.e_l0});
    if (v.e_cv[1]) check(int'(v.req), "port1 idx", {4'd0, clr_lq_idx_o[7:4]}, {4'd0, v.e_l1});
  endtask

  initial begin
    drive('0);
    #1;
    check(10, "reset clr_valid", {6'd0, clr_valid_o}, 8'd0); // R10
    check(10, "reset stall", {7'd0, stall_o}, 8'd0);          // R10
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      drive(VECS[i]);
      #1;
      expect_vec(VECS[i]);
    end
    // R10: reset mid-operation drops a recorded load
    @(negedge clk_i);
    drive('{4'd10, 1'b1,4'd4, 1'b1,3'd2, 1'b0,3'd0,1'b0, 1'b0,1'b0,2'b00,4'd0,4'd0});
    #1;
    check(10, "pre-reset shadowed", {7'd0, shadowed_o}, 8'd1);
    @(negedge clk_i);
    drive('0);
    rst_ni = 1'b0;
    #1;
    check(10, "in reset clr_valid", {6'd0, clr_valid_o}, 8'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    drive('{4'd10, 1'b0,4'd0, 1'b0,3'd0, 1'b1,3'd2,1'b0, 1'b0,1'b0,2'b00,4'd0,4'd0});
    #1;
    check(10, "post-reset release", {6'd0, clr_valid_o}, 8'd0);
    // R7/R11: refill all four slots after drain, no stall
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk_i);
      drive('{4'd7, 1'b1,4'(i), 1'b1,3'd4, 1'b0,3'd0,1'b0, 1'b0,1'b0,2'b00,4'd0,4'd0});
      #1;
      check(7, "refill shadowed", {7'd0, shadowed_o}, 8'd1);
      check(7, "refill stall", {7'd0, stall_o}, 8'd0);
    end
    @(negedge clk_i);
    drive('0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule